// File: doc/BRIEF.md
# Two-Level Address Translation Walker with Large-Page Support

This block translates a 32-bit virtual address into a 36-bit physical address by fetching the paging structures from memory. A request carries a virtual address. The directory base, the large-page enable and the high-address extension enable are captured together with it. The walker first reads one directory entry from a 4 KiB directory that holds 1024 four-byte slots. Most walks then read a second entry from a 4 KiB table that also holds 1024 slots, and that entry maps a 4 KiB page.

When large pages are enabled and the fetched directory entry has its size flag (bit 7) set, the walk ends after that first read. The result is a 4 MiB mapping, and it can optionally carry four extra high physical address bits taken from the entry. If the size flag is clear, or large pages are disabled, the walk goes on to the table exactly as an ordinary two-level walk would.

Memory is reached through a one-word read port. The walker raises a single-cycle read request and then waits for a valid strobe carrying the data. The result is a one-cycle done pulse with the physical address and a size flag that is 1 for large pages, so it can feed a translation cache fill directly. A missing (not-present) entry gives a one-cycle fault pulse instead.

Top module: `pgwalk_top`

## Requirements
- R1: After reset `req_ready` is 1 and `done`, `fault` and `mem_req` are 0.
- R2: A request is taken only while `req_ready` is 1 (idle). `req_vaddr`, `dir_base`, `large_en` and `ext36_en` are sampled at that edge. Later changes to them, and further `req_valid` during a walk, have no effect on the result.
- R3: The first read goes to address {dir_base[31:12], vaddr[31:22], 2'b00}, with `mem_req` high for exactly one cycle.
- R4: When `large_en` is 1 and the directory entry has bit 0 = 1 and bit 7 = 1, only one read is made. `done` then comes with `big_page` = 1 and `paddr[31:0]` = {entry[31:22], vaddr[21:0]}.
- R5: On a large-page result, `paddr[35:32]` equals entry bits [16:13] when `ext36_en` was 1, and 0 otherwise.
- R6: When a present directory entry does not select a large page, a second read goes to {entry[31:12], vaddr[21:12], 2'b00}. A present table entry then gives `big_page` = 0 and `paddr` = {4'b0, table_entry[31:12], vaddr[11:0]}.
- R7: With `large_en` = 0, bit 7 of the directory entry has no effect: the walk always reads the table.
- R8: If bit 0 (present) of a fetched entry is 0, `fault` pulses for one cycle, no further read is made and no `done` follows.
- R9: `done` and `fault` are single-cycle pulses that are never high together. `req_ready` is 1 again on the cycle after either pulse.
- R10: The walker waits any number of cycles for `mem_rvalid`. A `mem_rvalid` that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle; request taken when both high |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Directory base; bits [31:12] used |
| large_en | input | 1 | Enables 4 MiB directory mappings |
| ext36_en | input | 1 | Enables high address bits from large entries |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address, valid with `mem_req` |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | Translation complete pulse |
| paddr | output | 36 | Physical address, valid with `done` |
| big_page | output | 1 | 1 when the result maps a 4 MiB page |
| fault | output | 1 | Not-present entry pulse |

## Verification
The sweep crosses address extremes (all zeros, all ones) with base values whose low 12 bits are set. A walker that failed to mask them would put garbage in the entry offset. Each combination of size flag, large enable and extension enable is run, so a walker that honoured bit 7 while large pages were off would skip the table read and report a large page. A walker that leaked entry bits [16:13] with the extension off would show nonzero high bits. Not-present entries at either level must fault without a second read or a done pulse.

During every walk the request inputs are scrambled and `req_valid` is held high. A design that re-sampled them would translate the wrong address or start a spurious walk. Read latencies of zero to two cycles and stray valid strobes while idle expose a walker that assumed a fixed latency or reacted to unsolicited data.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int VA_W      = 32;
  localparam int EXT_W     = 4;
  localparam int PA_W      = VA_W + EXT_W;
  localparam int SMALL_SH  = 12;
  localparam int LARGE_SH  = 22;
  localparam int IDX_W     = LARGE_SH - SMALL_SH;
  localparam int FRAME_W   = VA_W - SMALL_SH;
  localparam int LFRAME_W  = VA_W - LARGE_SH;
  localparam int PRES_BIT  = 0;
  localparam int SIZE_BIT  = 7;
  localparam int EXT_LO    = 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_DIR,
    ST_WAIT_DIR,
    ST_READ_TBL,
    ST_WAIT_TBL,
    ST_DONE
  } walk_state_t;

  function automatic logic [VA_W-1:0] dir_slot_addr(
    input logic [FRAME_W-1:0] base_frame,
    input logic [IDX_W-1:0]   dir_idx
  );
    return {base_frame, dir_idx, 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] tbl_slot_addr(
    input logic [FRAME_W-1:0] tbl_frame,
    input logic [IDX_W-1:0]   tbl_idx
  );
    return {tbl_frame, tbl_idx, 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] large_phys(
    input logic [LFRAME_W-1:0] frame,
    input logic [EXT_W-1:0]    hi_bits,
    input logic                use_hi,
    input logic [LARGE_SH-1:0] offset
  );
    logic [EXT_W-1:0] hi;
    hi = use_hi ? hi_bits : '0;
    return {hi, frame, offset};
  endfunction

  function automatic logic [PA_W-1:0] small_phys(
    input logic [FRAME_W-1:0]  frame,
    input logic [SMALL_SH-1:0] offset
  );
    return {{EXT_W{1'b0}}, frame, offset};
  endfunction

endpackage

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_rvalid,
  input  logic        entry_present,
  input  logic        entry_large,
  output walk_state_t state,
  output logic        accept,
  output logic        dir_take,
  output logic        tbl_take,
  output logic        large_hit,
  output logic        fault_q
);

  walk_state_t nxt;
  logic        miss;

  always_comb begin
    accept    = (state == ST_IDLE) && req_valid;
    dir_take  = (state == ST_WAIT_DIR) && mem_rvalid;
    tbl_take  = (state == ST_WAIT_TBL) && mem_rvalid;
    large_hit = dir_take && entry_present && entry_large;
    miss      = (dir_take || tbl_take) && !entry_present;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (accept) nxt = ST_READ_DIR;
      ST_READ_DIR: nxt = ST_WAIT_DIR;
      ST_WAIT_DIR: begin
        if (dir_take) begin
          if (!entry_present)   nxt = ST_IDLE;
          else if (entry_large) nxt = ST_DONE;
          else                  nxt = ST_READ_TBL;
        end
      end
      ST_READ_TBL: nxt = ST_WAIT_TBL;
      ST_WAIT_TBL: begin
        if (tbl_take) nxt = entry_present ? ST_DONE : ST_IDLE;
      end
      ST_DONE:     nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state   <= nxt;
      fault_q <= miss;
    end
  end

endmodule

// File: rtl/pgwalk_path.sv
module pgwalk_path
  import pgwalk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  walk_state_t     state,
  input  logic            accept,
  input  logic            dir_take,
  input  logic            tbl_take,
  input  logic            large_hit,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [VA_W-1:0] dir_base,
  input  logic            large_en,
  input  logic            ext36_en,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            entry_present,
  output logic            entry_large,
  output logic [VA_W-1:0] mem_addr,
  output logic [PA_W-1:0] paddr,
  output logic            big_page
);

  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] tbl_q;
  logic               large_q;
  logic               ext_q;

  always_comb begin
    entry_present = mem_rdata[PRES_BIT];
    entry_large   = large_q && mem_rdata[SIZE_BIT];
    if (state == ST_READ_TBL)
      mem_addr = tbl_slot_addr(tbl_q, va_q[LARGE_SH-1:SMALL_SH]);
    else
      mem_addr = dir_slot_addr(base_q, va_q[VA_W-1:LARGE_SH]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q     <= '0;
      base_q   <= '0;
      tbl_q    <= '0;
      large_q  <= 1'b0;
      ext_q    <= 1'b0;
      paddr    <= '0;
      big_page <= 1'b0;
    end else begin
      if (accept) begin
        va_q    <= req_vaddr;
        base_q  <= dir_base[VA_W-1:SMALL_SH];
        large_q <= large_en;
        ext_q   <= ext36_en;
      end
      if (dir_take) tbl_q <= mem_rdata[VA_W-1:SMALL_SH];
      if (large_hit) begin
        paddr    <= large_phys(mem_rdata[VA_W-1:LARGE_SH],
                               mem_rdata[EXT_LO+EXT_W-1:EXT_LO],
                               ext_q, va_q[LARGE_SH-1:0]);
        big_page <= 1'b1;
      end else if (tbl_take) begin
        paddr    <= small_phys(mem_rdata[VA_W-1:SMALL_SH], va_q[SMALL_SH-1:0]);
        big_page <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [VA_W-1:0]     dir_base,
  input  logic                large_en,
  input  logic                ext36_en,
  output logic                mem_req,
  output logic [VA_W-1:0]     mem_addr,
  input  logic                mem_rvalid,
  input  logic [VA_W-1:0]     mem_rdata,
  output logic                done,
  output logic [PA_W-1:0]     paddr,
  output logic                big_page,
  output logic                fault
);

  walk_state_t state;
  logic        accept;
  logic        dir_take;
  logic        tbl_take;
  logic        large_hit;
  logic        entry_present;
  logic        entry_large;
  logic        fault_q;

  pgwalk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_rvalid    (mem_rvalid),
    .entry_present (entry_present),
    .entry_large   (entry_large),
    .state         (state),
    .accept        (accept),
    .dir_take      (dir_take),
    .tbl_take      (tbl_take),
    .large_hit     (large_hit),
    .fault_q       (fault_q)
  );

  pgwalk_path u_path (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .accept        (accept),
    .dir_take      (dir_take),
    .tbl_take      (tbl_take),
    .large_hit     (large_hit),
    .req_vaddr     (req_vaddr),
    .dir_base      (dir_base),
    .large_en      (large_en),
    .ext36_en      (ext36_en),
    .mem_rdata     (mem_rdata),
    .entry_present (entry_present),
    .entry_large   (entry_large),
    .mem_addr      (mem_addr),
    .paddr         (paddr),
    .big_page      (big_page)
  );

  always_comb begin
    req_ready = (state == ST_IDLE);
    mem_req   = (state == ST_READ_DIR) || (state == ST_READ_TBL);
    done      = (state == ST_DONE);
    fault     = fault_q;
  end

endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker
  import pgwalk_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req,
  input logic            done,
  input logic            fault,
  input logic            big_page,
  input logic [PA_W-1:0] paddr,
  input logic            large_hit,
  input logic            tbl_take
);

  p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_busy_when_reading_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_accept_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_large_one_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    large_hit |=> (done && big_page && !mem_req));

  p_small_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_take |=> (fault || (done && !big_page && paddr[PA_W-1:VA_W] == '0)));

  p_ready_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

endmodule

bind pgwalk_top pgwalk_checker u_pgwalk_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .done      (done),
  .fault     (fault),
  .big_page  (big_page),
  .paddr     (paddr),
  .large_hit (large_hit),
  .tbl_take  (tbl_take)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] dir_base = '0;
  logic        large_en = 1'b0;
  logic        ext36_en = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [35:0] paddr;
  logic        big_page;
  logic        fault;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .dir_base(dir_base), .large_en(large_en),
    .ext36_en(ext36_en), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
    .paddr(paddr), .big_page(big_page), .fault(fault)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails = 0;

  // memory model state
  logic [31:0] exp_dir_addr, exp_tbl_addr, cur_pde, cur_pte;
  int          rd_count = 0;
  int          lat = 0;
  logic        stray = 1'b0;
  logic        pending = 1'b0;
  int          cnt = 0;
  logic [31:0] pend_data = '0;

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_rdata  = 32'hDEAD_BEEF;
      if (stray) begin
        stray      = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = 32'hFFFF_FFFF;
      end else if (pending) begin
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = pend_data;
          pending    = 1'b0;
        end else cnt--;
      end
      if (mem_req) begin
        rd_count++;
        if (rd_count == 1) begin
          chk(mem_addr == exp_dir_addr, "R3 dir address", 64'(mem_addr), 64'(exp_dir_addr));
          pend_data = cur_pde;
        end else begin
          chk(mem_addr == exp_tbl_addr, "R6 table address", 64'(mem_addr), 64'(exp_tbl_addr));
          pend_data = cur_pte;
        end
        pending = 1'b1;
        cnt     = lat;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  function automatic logic [31:0] mix(input int n);
    logic [31:0] h;
    h = 32'(n) * 32'h9E37_79B9;
    return h ^ (h >> 15) ^ 32'h5A5A_3C3C;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && fault == 1'b0 && mem_req == 1'b0,
        "R1 reset outputs", {60'd0, req_ready, done, fault, mem_req}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 idle after reset", 64'(req_ready), 64'd1);

    for (int vi = 0; vi < 6; vi++)
    for (int bi = 0; bi < 2; bi++)
    for (int le = 0; le < 2; le++)
    for (int ee = 0; ee < 2; ee++)
    for (int ps = 0; ps < 2; ps++)
    for (int pd = 0; pd < 2; pd++)
    for (int pt = 0; pt < 2; pt++)
    for (int lt = 0; lt < 3; lt++) begin
      logic [31:0] va, base, pde, pte;
      logic        exp_fault, exp_big;
      logic [35:0] exp_pa;
      int          exp_reads;
      logic        got_done, got_fault;
      logic [35:0] got_pa;
      logic        got_big;
      int          seed;
      seed = ((((((vi * 2 + bi) * 2 + le) * 2 + ee) * 2 + ps) * 2 + pd) * 2 + pt) * 3 + lt;
      va   = (vi == 0) ? 32'h0 : (vi == 1) ? 32'hFFFF_FFFF : mix(seed + 7);
      base = bi ? 32'hABCD_E7FF : 32'h0000_1FFF;
      pde  = mix(seed + 1000);
      pde[0] = pd[0];
      pde[7] = ps[0];
      pte  = mix(seed + 2000);
      pte[0] = pt[0];

      // expected values, from the requirements
      exp_dir_addr = {base[31:12], va[31:22], 2'b00};
      exp_tbl_addr = {pde[31:12], va[21:12], 2'b00};
      cur_pde = pde;
      cur_pte = pte;
      lat     = lt;
      exp_big = 1'b0;
      exp_pa  = '0;
      if (!pd[0]) begin
        exp_fault = 1'b1; exp_reads = 1;
      end else if (le[0] && ps[0]) begin
        exp_fault = 1'b0; exp_reads = 1; exp_big = 1'b1;
        exp_pa = {(ee[0] ? pde[16:13] : 4'h0), pde[31:22], va[21:0]};
      end else begin
        exp_reads = 2;
        exp_fault = !pt[0];
        if (pt[0]) exp_pa = {4'h0, pte[31:12], va[11:0]};
      end

      // R10: unsolicited read data while idle must be ignored
      if (lt == 2) begin
        stray = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!done && !fault && req_ready, "R10 stray rvalid ignored",
            {61'd0, done, fault, req_ready}, 64'd1);
      end

      rd_count  = 0;
      req_vaddr = va;
      dir_base  = base;
      large_en  = le[0];
      ext36_en  = ee[0];
      req_valid = 1'b1;
      got_done = 1'b0; got_fault = 1'b0; got_pa = '0; got_big = 1'b0;
      for (int w = 0; w < 40; w++) begin
        @(negedge clk);
        // R2: scramble request inputs once the walk has started
        req_vaddr = ~va ^ mix(w);
        dir_base  = ~base;
        large_en  = ~le[0];
        ext36_en  = ~ee[0];
        if (done || fault) begin
          got_done = done; got_fault = fault; got_pa = paddr; got_big = big_page;
          break;
        end
      end
      req_valid = 1'b0;

      chk(got_fault == exp_fault && got_done == !exp_fault,
          exp_fault ? "R8 fault outcome" : "R2 done outcome",
          {62'd0, got_done, got_fault}, {62'd0, !exp_fault, exp_fault});
      if (!exp_fault) begin
        chk(got_big == exp_big, exp_big ? "R4 size flag large" : "R7 size flag small",
            64'(got_big), 64'(exp_big));
        chk(got_pa == exp_pa, exp_big ? "R5 large paddr" : "R6 small paddr",
            64'(got_pa), 64'(exp_pa));
      end
      chk(rd_count == exp_reads, (le == 0 && ps == 1) ? "R7 read count" : "R4 read count",
          64'(rd_count), 64'(exp_reads));

      @(negedge clk);
      chk(!done && !fault && req_ready, "R9 single pulse then ready",
          {61'd0, done, fault, req_ready}, 64'd1);
      chk(rd_count == exp_reads, "R8 no extra read", 64'(rd_count), 64'(exp_reads));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule